// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and derives from them the node's fault state. The node is error-active, error-passive or bus-off, and a warning flag is raised as a separate status bit. The block receives single-cycle strobes from the surrounding controller: one for a transmit error, one for a receive error, one for a successful transmission and one for a successful reception. It also receives the sampled bus level together with a strobe that marks each bit time. Error detection, bit timing and framing are handled elsewhere.

Once the transmit counter overflows, the node is bus-off. Software, or the automatic bus-on option, must clear the Init control bit before the node starts its way back. The node then has to observe 129 idle periods of 11 recessive bits each. Changing Init while this runs has no effect on the count. Finishing the recovery sequence is the only event that returns both counters to zero.

Top module: `can_fault_conf`

## Requirements
- R1: After synchronous reset both counters read 0 and the warning, passive, bus-off and Init readback outputs are all 0.
- R2: Outside bus-off, a transmit error strobe adds 8 to the transmit counter and a transmit success strobe subtracts 1, never going below 0. When both strobes arrive in the same cycle, the net change is +7.
- R3: Outside bus-off, a receive error strobe adds 1 to the receive counter and a receive success strobe subtracts 1. The result is held between 0 and 255. A full receive counter never causes bus-off.
- R4: The warning output is 1 whenever either counter is 96 or higher.
- R5: Outside bus-off, the passive output is 1 exactly when either counter is above 127. The node returns to active when both counters are 127 or less.
- R6: A transmit error that would take the transmit counter above 255 puts the node in bus-off. In that same update the transmit counter reads 255 and the Init readback reads 1.
- R7: While bus-off, all four error and success strobes leave both counters unchanged.
- R8: Recovery starts only after Init reads 0 while bus-off. Init is cleared by a write (write enable with data 0) or, when auto-bus-on is 1, one cycle after Init was seen set. Bits seen before recovery starts do not count.
- R9: Recovery ends after 129 runs of 11 recessive bits. A bit counts only in a cycle with the bit strobe high, and bus level 1 means recessive. A dominant bit (0) restarts the current run but keeps the completed runs.
- R10: Writes to Init during recovery neither shorten nor restart the run count.
- R11: At the end of recovery both counters become 0 and the node is active. An Init write outside bus-off leaves the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| bit_tick_i | input | 1 | One pulse per bit time |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| init_we_i | input | 1 | Write strobe for the Init bit |
| init_wd_i | input | 1 | Value written to Init |
| auto_bus_on_i | input | 1 | Clears Init automatically in bus-off |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| warn_o | output | 1 | Either counter at or above 96 |
| passive_o | output | 1 | Node is error-passive |
| busoff_o | output | 1 | Node is bus-off |
| init_ack_o | output | 1 | Init readback |

## Verification
Two things can land in the same cycle. An error strobe and a success strobe can hit the same counter together, and an Init write can coincide with a counted recovery bit. The random phase raises all four strobes, Init writes and bit strobes independently in each cycle, so both overlaps occur many times. Directed steps force an error and a success onto a zero counter, where the expected result is 7. They also toggle Init on the same cycles as recessive recovery bits and expect the completion cycle to stay where the bit count alone puts it. A cycle-level reference model in the bench judges every cycle.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_err_ctr.sv
module fc_err_ctr #(
  parameter int W    = 8,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         ovf
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, cnt} + (inc ? SW'(STEP) : '0);
    if (dec && sum != '0) sum = sum - SW'(1);
  end

  assign ovf = en & sum[W];
  assign nxt = sum[W] ? '1 : sum[W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= nxt;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec && !clr) |=> $stable(cnt)); // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt)); // R7
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
  parameter int RUN_LEN = 11,
  parameter int RUN_NUM = 129
) (
  input  logic clk,
  input  logic rst,
  input  logic busoff,
  input  logic arm,
  input  logic bit_tick,
  input  logic bus_bit,
  output logic done
);
  localparam int RW = $clog2(RUN_LEN);
  localparam int NW = $clog2(RUN_NUM + 1);

  logic          active_q;
  logic [RW-1:0] run_q;
  logic [NW-1:0] num_q;
  logic          last_bit, last_run;

  assign last_bit = (run_q == RW'(RUN_LEN - 1));
  assign last_run = (num_q == NW'(RUN_NUM - 1));
  assign done     = active_q & bit_tick & bus_bit & last_bit & last_run;

  always_ff @(posedge clk) begin
    if (rst || !busoff) begin
      active_q <= 1'b0;
      run_q    <= '0;
      num_q    <= '0;
    end else begin
      if (!active_q && arm) active_q <= 1'b1;
      if (active_q && bit_tick) begin
        if (!bus_bit) begin
          run_q <= '0;
        end else if (last_bit) begin
          run_q <= '0;
          num_q <= num_q + NW'(1);
        end else begin
          run_q <= run_q + RW'(1);
        end
      end
    end
  end

  AST_RCV_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(active_q) |-> $past(arm)); // R8
  AST_DOM_RESTART: assert property (@(posedge clk) disable iff (rst)
    (active_q && bit_tick && !bus_bit) |=> (run_q == '0)); // R9
  AST_NUM_BOUND: assert property (@(posedge clk) disable iff (rst)
    num_q <= NW'(RUN_NUM)); // R9
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 127,
  parameter int RUN_LEN     = 11,
  parameter int RUN_NUM     = 129
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             bit_tick_i,
  input  logic             bus_bit_i,
  input  logic             init_we_i,
  input  logic             init_wd_i,
  input  logic             auto_bus_on_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             warn_o,
  output logic             passive_o,
  output logic             busoff_o,
  output logic             init_ack_o
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LIM);

  fc_state_e        state_q;
  logic             init_q;
  logic             live;
  logic             rcv_done;
  logic [CNT_W-1:0] tec_nxt, rec_nxt;
  logic             tec_ovf, rec_ovf;

  assign live = (state_q != FC_BUSOFF);

  fc_err_ctr #(.W(CNT_W), .STEP(TX_STEP)) u_tec (
    .clk(clk), .rst(rst), .en(live), .clr(rcv_done),
    .inc(tx_err_i), .dec(tx_ok_i),
    .cnt(tec_o), .nxt(tec_nxt), .ovf(tec_ovf)
  );

  fc_err_ctr #(.W(CNT_W), .STEP(RX_STEP)) u_rec (
    .clk(clk), .rst(rst), .en(live), .clr(rcv_done),
    .inc(rx_err_i), .dec(rx_ok_i),
    .cnt(rec_o), .nxt(rec_nxt), .ovf(rec_ovf)
  );

  fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_NUM(RUN_NUM)) u_rcv (
    .clk(clk), .rst(rst), .busoff(!live), .arm(!init_q),
    .bit_tick(bit_tick_i), .bus_bit(bus_bit_i), .done(rcv_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FC_ACTIVE;
    end else if (!live) begin
      if (rcv_done) state_q <= FC_ACTIVE;
    end else if (tec_ovf) begin
      state_q <= FC_BUSOFF;
    end else if (tec_nxt > PASS_V || rec_nxt > PASS_V) begin
      state_q <= FC_PASSIVE;
    end else begin
      state_q <= FC_ACTIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            init_q <= 1'b0;
    else if (live && tec_ovf)           init_q <= 1'b1;
    else if (init_we_i)                 init_q <= init_wd_i;
    else if (!live && auto_bus_on_i && init_q) init_q <= 1'b0;
  end

  assign warn_o     = (tec_o >= WARN_V) || (rec_o >= WARN_V);
  assign passive_o  = (state_q == FC_PASSIVE);
  assign busoff_o   = (state_q == FC_BUSOFF);
  assign init_ack_o = init_q;

  AST_BUSOFF_TEC_MAX: assert property (@(posedge clk) disable iff (rst)
    busoff_o |-> (tec_o == '1)); // R6
  AST_BUSOFF_INIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busoff_o) |-> init_ack_o); // R6
  AST_PASSIVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    passive_o |-> (tec_o > PASS_V || rec_o > PASS_V)); // R5
  AST_REC_NO_BUSOFF: assert property (@(posedge clk) disable iff (rst)
    (live && rec_ovf && !tec_ovf) |=> !busoff_o); // R3
  AST_EXIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(busoff_o) |-> (tec_o == '0 && rec_o == '0)); // R11
endmodule

// File: tb/can_fault_conf_bench.sv
`timescale 1ns/1ps
module can_fault_conf_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0;
  logic bit_tick = 0, bus_bit = 1, init_we = 0, init_wd = 0, abo = 0;
  logic [7:0] tec, rec;
  logic warn, passive, busoff, init_ack;

  int total = 0;
  int bad   = 0;

  int m_tec, m_rec, m_st, m_run, m_num;
  bit m_init, m_act;

  always #10 clk = ~clk;

  can_fault_conf u_can_fault_conf (
    .clk(clk), .rst(rst),
    .tx_err_i(tx_err), .rx_err_i(rx_err), .tx_ok_i(tx_ok), .rx_ok_i(rx_ok),
    .bit_tick_i(bit_tick), .bus_bit_i(bus_bit),
    .init_we_i(init_we), .init_wd_i(init_wd), .auto_bus_on_i(abo),
    .tec_o(tec), .rec_o(rec), .warn_o(warn), .passive_o(passive),
    .busoff_o(busoff), .init_ack_o(init_ack)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int clamp(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic model_reset();
    m_tec = 0; m_rec = 0; m_st = 0; m_run = 0; m_num = 0;
    m_init = 0; m_act = 0;
  endtask

  task automatic model_step(input bit te, re, to, ro, bt, bb, iwe, iwd);
    bit old_init = m_init;
    bit done = 0;
    int t, r;
    if (m_st == 2) begin
      if (m_act && bt) begin
        if (!bb) m_run = 0;
        else if (m_run == 10) begin
          m_run = 0;
          if (m_num == 128) done = 1;
          m_num++;
        end else m_run++;
      end
      if (!m_act && !old_init) m_act = 1;
      if (iwe) m_init = iwd;
      else if (abo && old_init) m_init = 0;
      if (done) begin
        m_tec = 0; m_rec = 0; m_st = 0; m_act = 0; m_run = 0; m_num = 0;
      end
    end else begin
      t = clamp(m_tec + (te ? 8 : 0) - (to ? 1 : 0), 1000);
      r = clamp(m_rec + (re ? 1 : 0) - (ro ? 1 : 0), 255);
      m_rec = r;
      if (t > 255) begin
        m_tec = 255; m_st = 2; m_init = 1;
        m_act = 0; m_run = 0; m_num = 0;
      end else begin
        m_tec = t;
        m_st = (t > 127 || r > 127) ? 1 : 0;
        if (iwe) m_init = iwd;
      end
    end
  endtask

  task automatic compare_all();
    check("R2 tec", int'(tec), m_tec);
    check("R3 rec", int'(rec), m_rec);
    check("R4 warn", int'(warn), (m_tec >= 96 || m_rec >= 96) ? 1 : 0);
    check("R5 passive", int'(passive), (m_st == 1) ? 1 : 0);
    check("R6 busoff", int'(busoff), (m_st == 2) ? 1 : 0);
    check("R8 init_ack", int'(init_ack), int'(m_init));
  endtask

  task automatic tick(input bit te, re, to, ro, bt, bb, iwe, iwd);
    tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro;
    bit_tick = bt; bus_bit = bb; init_we = iwe; init_wd = iwd;
    @(posedge clk);
    #2;
    model_step(te, re, to, ro, bt, bb, iwe, iwd);
    compare_all();
    @(negedge clk);
    tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0;
    bit_tick = 0; bus_bit = 1; init_we = 0; init_wd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    check("R1 tec", int'(tec), 0);
    check("R1 rec", int'(rec), 0);
    check("R1 flags", int'({warn, passive, busoff, init_ack}), 0);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic random_phase(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      tick(($urandom % 6) == 0, ($urandom % 5) == 0,
           ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 2) == 0, ($urandom % 40) != 0,
           ($urandom % 60) == 0, ($urandom % 2) == 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R2: increments, combined strobes, floor at zero
    tick(1, 0, 0, 0, 0, 1, 0, 0);
    check("R2 tx error adds 8", int'(tec), 8);
    tick(1, 0, 1, 0, 0, 1, 0, 0);
    check("R2 err plus ok net 7", int'(tec), 15);
    for (int i = 0; i < 20; i++) tick(0, 0, 1, 0, 0, 1, 0, 0);
    check("R2 floor at zero", int'(tec), 0);
    do_reset();
    tick(1, 0, 1, 0, 0, 1, 0, 0);
    check("R2 same-cycle from zero", int'(tec), 7);

    // R4, R5, R3 on the receive counter
    do_reset();
    for (int i = 0; i < 95; i++) tick(0, 1, 0, 0, 0, 1, 0, 0);
    check("R4 warn low at 95", int'(warn), 0);
    tick(0, 1, 0, 0, 0, 1, 0, 0);
    check("R4 warn high at 96", int'(warn), 1);
    for (int i = 0; i < 31; i++) tick(0, 1, 0, 0, 0, 1, 0, 0);
    check("R5 not passive at 127", int'(passive), 0);
    tick(0, 1, 0, 0, 0, 1, 0, 0);
    check("R5 passive at 128", int'(passive), 1);
    for (int i = 0; i < 140; i++) tick(0, 1, 0, 0, 0, 1, 0, 0);
    check("R3 rec held at 255", int'(rec), 255);
    check("R3 no bus-off from rec", int'(busoff), 0);
    tick(0, 0, 0, 1, 0, 1, 0, 0);
    check("R3 rec decrement", int'(rec), 254);

    // R11: Init toggles outside bus-off keep counters
    tick(0, 0, 0, 0, 0, 1, 1, 1);
    tick(0, 0, 0, 0, 0, 1, 1, 0);
    check("R11 init write keeps rec", int'(rec), 254);
    for (int i = 0; i < 200; i++) tick(0, 0, 0, 1, 0, 1, 0, 0);
    check("R5 back to active", int'(passive), 0);

    // R6: bus-off entry
    do_reset();
    for (int i = 0; i < 31; i++) tick(1, 0, 0, 0, 0, 1, 0, 0);
    check("R6 tec 248 before overflow", int'(tec), 248);
    check("R6 not yet bus-off", int'(busoff), 0);
    tick(1, 0, 0, 0, 0, 1, 0, 0);
    check("R6 bus-off entered", int'(busoff), 1);
    check("R6 tec reads 255", int'(tec), 255);
    check("R6 init forced", int'(init_ack), 1);

    // R7: strobes ignored in bus-off
    tick(0, 1, 1, 0, 0, 1, 0, 0);
    tick(1, 0, 0, 1, 0, 1, 0, 0);
    check("R7 tec frozen", int'(tec), 255);
    check("R7 rec frozen", int'(rec), 0);

    // R8/R9: bits before Init is cleared are not counted
    idle_bits(11 * 130);
    check("R8 no recovery while Init set", int'(busoff), 1);

    // R8: software clears Init; recovery with a dominant restart and Init toggles
    tick(0, 0, 0, 0, 0, 1, 1, 0);
    check("R8 init cleared by write", int'(init_ack), 0);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    idle_bits(5);
    tick(0, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 1418; i++) begin
      if (i == 300) tick(0, 0, 0, 0, 1, 1, 1, 1);
      else if (i == 301) tick(0, 0, 0, 0, 1, 1, 1, 0);
      else if (i == 900) tick(0, 0, 0, 0, 1, 1, 1, 1);
      else tick(0, 0, 0, 0, 1, 1, 0, 0);
    end
    check("R9 still bus-off one bit short", int'(busoff), 1);
    check("R10 Init toggles do not shorten", int'(busoff), 1);
    tick(0, 0, 0, 0, 1, 1, 0, 0);
    check("R9 recovery complete", int'(busoff), 0);
    check("R11 tec zero after recovery", int'(tec), 0);
    check("R11 rec zero after recovery", int'(rec), 0);

    // R8: auto-bus-on path
    do_reset();
    abo = 1;
    for (int i = 0; i < 32; i++) tick(1, 0, 0, 0, 0, 1, 0, 0);
    check("R6 bus-off with auto-bus-on", int'(busoff), 1);
    check("R8 init set on entry", int'(init_ack), 1);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    check("R8 auto-bus-on clears init", int'(init_ack), 0);
    tick(0, 0, 0, 0, 0, 1, 0, 0);
    idle_bits(1418);
    check("R9 auto path one bit short", int'(busoff), 1);
    tick(0, 0, 0, 0, 1, 1, 0, 0);
    check("R9 auto path recovered", int'(busoff), 0);

    // random phases against the model
    do_reset();
    abo = 0;
    random_phase(20000);
    do_reset();
    abo = 1;
    random_phase(20000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule